// File: doc/BRIEF.md
# Programmable Serial Audio Frame Delay

This block sits in a serial audio chain ahead of the final reclocking stage. It takes a stereo I2S stream (bit clock, word clock, serial data) and produces two data lines that share the incoming clocks. Line A carries each stereo frame unchanged. Line B carries the same left and right words shifted later by a whole number of frames. A downstream four-channel converter can then run a driver on line B that is time-aligned against the one on line A. The block drives no timing of its own: both clocks go straight through, and only data is touched.

The frame delay comes from one of five per-rate registers, chosen by a sample-rate code. Each rate keeps its own frame count, so the delay in time stays the same when the playback rate changes. The registers are written on a system clock and carried across into the bit-clock domain. Frames go into a circular buffer as they complete. Line B reads the buffer at an offset behind the write pointer. Line B stays silent until the buffer holds enough frames written under the current setting.

Top module: `i2s_frame_delay`

## Requirements
- R1: The bit clock and word clock outputs equal the bit clock and word clock inputs at all times.
- R2: The input uses I2S framing: 32 bit clocks per channel slot, MSB first, data launched one bit clock after each word-clock edge, word clock low for left. Line A reproduces every frame bit for bit in the same framing. It is launched on the rising bit-clock edge exactly one frame (64 bit clocks) after the same bit went in.
- R3: With an active delay D, the slot in which line A carries input frame n carries frame n−D on line B, bit for bit.
- R4: Rate code 0 means 44.1 kHz, 1 means 48 kHz, 2 means 88.2 kHz, 3 means 96 kHz and 4 means 192 kHz. Each code selects the delay register of the same index. Codes 5, 6 and 7 mute line B (all zeros).
- R5: A write on a rising system-clock edge with the write enable high and an address from 0 to 4 sets that rate's delay register. Writes to addresses 5 to 7 change nothing. All registers reset to 0.
- R6: A written value above the buffer depth minus one (2^ADDR_W−1, which is 1023 by default) is stored as that maximum.
- R7: With an active delay of 0, line B equals line A.
- R8: A new rate code or a new active delay value that arrives early in a frame takes effect when that frame completes. Call that frame m. Line B is then zero for frames m to m+D−1 and carries frame n−D for n ≥ m+D. Rewriting an unchanged value causes no restart. After reset, counting starts with the first captured frame.
- R9: After reset both data lines are low. Capture begins with the first complete frame that follows the first falling word-clock edge.
- R10: Writing the register of a rate that is not selected leaves line B unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Clock for the register write port |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| regWe | input | 1 | Delay register write enable |
| regAddr | input | 3 | Register index, equal to the rate code |
| regWdata | input | DLY_W | Requested delay in frames |
| rateCode | input | 3 | Current sample-rate code |
| bclkIn | input | 1 | Incoming bit clock |
| wclkIn | input | 1 | Incoming word clock |
| sdIn | input | 1 | Incoming serial data |
| bclkOut | output | 1 | Forwarded bit clock |
| wclkOut | output | 1 | Forwarded word clock |
| sdOutA | output | 1 | Direct stereo data, one frame of latency |
| sdOutB | output | 1 | Delayed stereo data |

## Verification
Some properties are checked on every cycle. The write pointer advances by one per completed frame and holds otherwise. A frame loaded while gated leaves line B low. A bypass load makes the two lines agree. Writes to unused addresses and oversized values are handled as R5 and R6 require. The freshness count never falls between restarts. Other behaviour can only be shown by the bench scenarios, which cover the whole delay range of a small buffer, every rate code including the muted ones, clamping, repeated and foreign writes, and the frames blanked after each change. In those scenarios a reference model decodes both output lines frame by frame and compares them against the frames that were sent.

// File: rtl/i2s_frame_delay_pkg.sv
package i2s_frame_delay_pkg;
  localparam int NUM_RATES = 5;
  localparam int RATE_W    = 3;

  // strobes from the control to the datapath, all in the bit-clock domain
  typedef struct packed {
    logic leftDone;   // left word complete: prefetch delayed frame
    logic frameDone;  // right word complete: write frame, load shifters
    logic gateB;      // delayed line may carry data for this frame
    logic bypass;     // delay is zero: delayed line takes the new frame
  } dlyStrobe_t;
endpackage

// File: rtl/i2s_frame_delay_regs.sv
module i2s_frame_delay_regs
  import i2s_frame_delay_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DLY_W  = 10
) (
  input  logic                        sysClk,
  input  logic                        rstN,
  input  logic                        regWe,
  input  logic [RATE_W-1:0]           regAddr,
  input  logic [DLY_W-1:0]            regWdata,
  input  logic                        bclk,
  output logic [NUM_RATES*ADDR_W-1:0] activeDly
);
  localparam int FLAT_W = NUM_RATES * ADDR_W;
  localparam logic [DLY_W-1:0] MAX_REQ = DLY_W'((1 << ADDR_W) - 1);

  logic [ADDR_W-1:0] sysDly [NUM_RATES];
  logic [ADDR_W-1:0] clampVal;
  logic [FLAT_W-1:0] sysFlat, syncA, syncB, syncC;

  assign clampVal = (regWdata > MAX_REQ) ? MAX_REQ[ADDR_W-1:0] : regWdata[ADDR_W-1:0];

  generate
    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
      always_ff @(posedge sysClk or negedge rstN) begin
        if (!rstN) sysDly[r] <= '0;
        else if (regWe && regAddr == RATE_W'(r)) sysDly[r] <= clampVal;
      end

      // R6
      clamp_store_chk: assert property (@(posedge sysClk) disable iff (!rstN)
        (regWe && regAddr == RATE_W'(r) && regWdata > MAX_REQ) |=> (sysDly[r] == MAX_REQ[ADDR_W-1:0]));
    end
  endgenerate

  always_comb begin
    for (int r = 0; r < NUM_RATES; r++) sysFlat[r*ADDR_W +: ADDR_W] = sysDly[r];
  end

  // two-flop crossing, then accept only a value seen equal on two cycles
  always_ff @(posedge bclk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      syncC     <= '0;
      activeDly <= '0;
    end else begin
      syncA <= sysFlat;
      syncB <= syncA;
      syncC <= syncB;
      if (syncB == syncC) activeDly <= syncC;
    end
  end

  // R5
  unused_addr_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (regWe && regAddr >= RATE_W'(NUM_RATES)) |=> $stable(sysFlat));
endmodule

// File: rtl/i2s_frame_delay_ctrl.sv
module i2s_frame_delay_ctrl
  import i2s_frame_delay_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                        bclk,
  input  logic                        rstN,
  input  logic                        wclkIn,
  input  logic [RATE_W-1:0]           rateCode,
  input  logic [NUM_RATES*ADDR_W-1:0] activeDly,
  output dlyStrobe_t                  stb,
  output logic [ADDR_W-1:0]           rdDelay
);
  localparam logic [ADDR_W-1:0] FRESH_MAX = '1;

  logic              wPrev, primed, synced;
  logic [RATE_W-1:0] rateS1, rateS2, curRate;
  logic [ADDR_W-1:0] curDelay, selDelay, freshCnt;
  logic              rateOk, curOk, edgeSeen, restart;

  always_comb begin
    selDelay = '0;
    for (int r = 0; r < NUM_RATES; r++) begin
      if (rateS2 == RATE_W'(r)) selDelay = activeDly[r*ADDR_W +: ADDR_W];
    end
    rateOk        = rateS2 < RATE_W'(NUM_RATES);
    curOk         = curRate < RATE_W'(NUM_RATES);
    edgeSeen      = primed && (wclkIn != wPrev);
    stb.leftDone  = synced && edgeSeen && !wPrev;
    stb.frameDone = synced && edgeSeen && wPrev;
    restart       = (rateS2 != curRate) || (selDelay != curDelay);
    if (restart) begin
      stb.gateB  = rateOk && (selDelay == '0);
      stb.bypass = (selDelay == '0);
    end else begin
      stb.gateB  = curOk && (freshCnt >= curDelay);
      stb.bypass = (curDelay == '0);
    end
  end

  assign rdDelay = curDelay;

  always_ff @(posedge bclk or negedge rstN) begin
    if (!rstN) begin
      wPrev    <= 1'b0;
      primed   <= 1'b0;
      synced   <= 1'b0;
      rateS1   <= '0;
      rateS2   <= '0;
      curRate  <= '0;
      curDelay <= '0;
      freshCnt <= '0;
    end else begin
      wPrev  <= wclkIn;
      primed <= 1'b1;
      rateS1 <= rateCode;
      rateS2 <= rateS1;
      if (edgeSeen && wPrev) synced <= 1'b1;
      if (stb.frameDone) begin
        curRate  <= rateS2;
        curDelay <= selDelay;
        if (restart) freshCnt <= ADDR_W'(1);
        else if (freshCnt != FRESH_MAX) freshCnt <= freshCnt + ADDR_W'(1);
      end
    end
  end

  // R8
  fresh_monotone_chk: assert property (@(posedge bclk) disable iff (!rstN)
    (stb.frameDone && !restart) |=> (freshCnt >= $past(freshCnt)));
endmodule

// File: rtl/i2s_frame_delay_path.sv
module i2s_frame_delay_path
  import i2s_frame_delay_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SLOT_W = 32
) (
  input  logic              bclk,
  input  logic              rstN,
  input  logic              sdIn,
  input  dlyStrobe_t        stb,
  input  logic [ADDR_W-1:0] rdDelay,
  output logic              sdOutA,
  output logic              sdOutB
);
  localparam int FRAME_W = 2 * SLOT_W;
  localparam int DEPTH   = 1 << ADDR_W;

  logic [SLOT_W-1:0]  shReg, wordNow, leftHold;
  logic [FRAME_W-1:0] frameNew, rdData, outA, outB;
  logic [ADDR_W-1:0]  wrPtr, rdPtr;
  logic [FRAME_W-1:0] frameMem [DEPTH];

  assign wordNow  = {shReg[SLOT_W-2:0], sdIn};
  assign frameNew = {leftHold, wordNow};
  assign rdPtr    = wrPtr - rdDelay;

  // buffer: read in the middle of a frame, write at its end
  always_ff @(posedge bclk) begin
    if (stb.leftDone)  rdData <= frameMem[rdPtr];
    if (stb.frameDone) frameMem[wrPtr] <= frameNew;
  end

  always_ff @(posedge bclk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      leftHold <= '0;
      wrPtr    <= '0;
      outA     <= '0;
      outB     <= '0;
    end else begin
      shReg <= wordNow;
      if (stb.leftDone) leftHold <= wordNow;
      if (stb.frameDone) begin
        wrPtr <= wrPtr + ADDR_W'(1);
        outA  <= frameNew;
        outB  <= stb.gateB ? (stb.bypass ? frameNew : rdData) : '0;
      end else begin
        outA <= {outA[FRAME_W-2:0], 1'b0};
        outB <= {outB[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign sdOutA = outA[FRAME_W-1];
  assign sdOutB = outB[FRAME_W-1];

  // R3
  ptr_step_chk: assert property (@(posedge bclk) disable iff (!rstN)
    stb.frameDone |=> (wrPtr == $past(wrPtr) + ADDR_W'(1)));
  // R3
  ptr_hold_chk: assert property (@(posedge bclk) disable iff (!rstN)
    !stb.frameDone |=> $stable(wrPtr));
  // R8
  gated_zero_chk: assert property (@(posedge bclk) disable iff (!rstN)
    (stb.frameDone && !stb.gateB) |=> !sdOutB);
  // R7
  bypass_match_chk: assert property (@(posedge bclk) disable iff (!rstN)
    (stb.frameDone && stb.gateB && stb.bypass) |=> (sdOutB == sdOutA));
endmodule

// File: rtl/i2s_frame_delay.sv
module i2s_frame_delay
  import i2s_frame_delay_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DLY_W  = 10,
  parameter int SLOT_W = 32
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DLY_W-1:0]  regWdata,
  input  logic [2:0]        rateCode,
  input  logic              bclkIn,
  input  logic              wclkIn,
  input  logic              sdIn,
  output logic              bclkOut,
  output logic              wclkOut,
  output logic              sdOutA,
  output logic              sdOutB
);
  logic [NUM_RATES*ADDR_W-1:0] activeDly;
  logic [ADDR_W-1:0]           rdDelay;
  dlyStrobe_t                  stb;

  // clocks pass straight through; only data is retimed
  assign bclkOut = bclkIn;
  assign wclkOut = wclkIn;

  i2s_frame_delay_regs #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_regs (
    .sysClk(sysClk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .bclk(bclkIn), .activeDly(activeDly)
  );

  i2s_frame_delay_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .bclk(bclkIn), .rstN(rstN), .wclkIn(wclkIn), .rateCode(rateCode),
    .activeDly(activeDly), .stb(stb), .rdDelay(rdDelay)
  );

  i2s_frame_delay_path #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_path (
    .bclk(bclkIn), .rstN(rstN), .sdIn(sdIn), .stb(stb), .rdDelay(rdDelay),
    .sdOutA(sdOutA), .sdOutB(sdOutB)
  );
endmodule

// File: tb/i2s_frame_delay_test.sv
module i2s_frame_delay_test;
  localparam int AW = 4;

  logic       sysClk = 0, bclkIn = 0, rstN = 0, regWe = 0, wclkIn = 0, sdIn = 0;
  logic [2:0] regAddr = '0, rateCode = '0;
  logic [9:0] regWdata = '0;
  logic       bclkOut, wclkOut, sdOutA, sdOutB;

  i2s_frame_delay #(.ADDR_W(AW), .DLY_W(10), .SLOT_W(32)) uut (
    .sysClk(sysClk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .rateCode(rateCode), .bclkIn(bclkIn), .wclkIn(wclkIn), .sdIn(sdIn),
    .bclkOut(bclkOut), .wclkOut(wclkOut), .sdOutA(sdOutA), .sdOutB(sdOutB)
  );

  always #10 sysClk = ~sysClk;   // 50 MHz
  always #40 bclkIn = ~bclkIn;

  int vectors = 0, fails = 0, frameNo = -1;
  bit done = 0;
  logic [63:0] sent [0:511];
  int snapD [0:511], snapM [0:511];
  bit snapV [0:511];
  int mRate = 0, mD = 0, mM = 1;
  bit mV = 1;
  int bReg [0:4];
  string phase = "R3";

  function automatic logic [63:0] mkFrame(int f);
    logic [31:0] fv, l, r;
    fv = f;
    l  = (fv * 32'h9E3779B9) ^ 32'hC3A50F81;
    r  = ~(fv * 32'h85EBCA6B) ^ {fv[15:0], 16'h1234};
    return {l, r};
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic checkFrame(int t, logic [63:0] oa, logic [63:0] ob);
    int src;
    logic [63:0] expA, expB;
    string tagA, tagB;
    src = t - 2;
    if (src < 1) begin
      expA = '0; expB = '0; tagA = "R9"; tagB = "R9";
    end else begin
      expA = sent[src]; tagA = "R2";
      if (!snapV[src]) begin expB = '0; tagB = "R4"; end
      else if (src - snapM[src] < snapD[src]) begin expB = '0; tagB = "R8"; end
      else begin
        expB = sent[src - snapD[src]];
        tagB = (snapD[src] == 0) ? "R7" : phase;
      end
    end
    vectors++;
    if (oa !== expA) begin
      fails++;
      $display("FAIL %s line A frame %0d: got %h expected %h", tagA, src, oa, expA);
    end
    vectors++;
    if (ob !== expB) begin
      fails++;
      $display("FAIL %s line B frame %0d: got %h expected %h", tagB, src, ob, expB);
    end
  endtask

  // R1: forwarded clocks follow the inputs, checked after each bit-clock edge
  always @(posedge bclkIn or negedge bclkIn) begin
    #5;
    if (!done) begin
      vectors++;
      if (bclkOut !== bclkIn || wclkOut !== wclkIn) begin
        fails++;
        $display("FAIL R1 clocks: got %b%b expected %b%b", bclkOut, wclkOut, bclkIn, wclkIn);
      end
    end
  end

  // frame source and output decoder
  initial begin
    logic [63:0] cur, prev, oa, ob;
    prev = '0; oa = '0; ob = '0;
    for (int f = 0; f < 512 && !done; f++) begin
      cur = mkFrame(f);
      sent[f] = cur;
      for (int p = 0; p < 64; p++) begin
        @(negedge bclkIn);
        oa[(p == 0) ? 0 : 64 - p] = sdOutA;
        ob[(p == 0) ? 0 : 64 - p] = sdOutB;
        if (p == 0) begin
          if (f >= 2) checkFrame(f, oa, ob);
          oa = '0; ob = '0;
          frameNo = f;
        end
        wclkIn = (p >= 32);
        sdIn   = (p == 0) ? prev[0] : cur[64 - p];
      end
      snapD[f] = mD; snapM[f] = mM; snapV[f] = mV;
      prev = cur;
    end
  end

  // apply a rate code and optionally a register write, updating the model
  task automatic setCfg(int rate, int addr, int data, bit wr);
    int newD;
    bit newV;
    rateCode = 3'(rate);
    if (wr) begin
      @(negedge sysClk);
      regWe = 1; regAddr = 3'(addr); regWdata = 10'(data);
      @(negedge sysClk);
      regWe = 0;
      if (addr < 5) bReg[addr] = (data > 15) ? 15 : data;   // R6 clamp, R5 ignore
    end
    newV = (rate < 5);
    newD = newV ? bReg[rate] : 0;
    if (rate != mRate || newD != mD) mM = frameNo;           // R8 restart
    mRate = rate; mD = newD; mV = newV;
  endtask

  initial begin
    int fr;
    for (int i = 0; i < 5; i++) bReg[i] = 0;
    wait (frameNo == 0);
    repeat (10) @(negedge bclkIn);
    rstN = 1;
    fr = 4;
    phase = "R3";
    for (int d = 0; d < 16; d++) begin
      wait (frameNo == fr); setCfg(0, 0, d, 1); fr += d + 3;
    end
    phase = "R6";
    wait (frameNo == fr); setCfg(0, 0, 20, 1); fr += 18;
    phase = "R8";
    wait (frameNo == fr); setCfg(0, 0, 15, 1); fr += 4;
    phase = "R10";
    wait (frameNo == fr); setCfg(0, 2, 7, 1); fr += 3;
    phase = "R4";
    wait (frameNo == fr);
    setCfg(0, 1, 3, 1); setCfg(0, 3, 9, 1); setCfg(0, 4, 1, 1); fr += 3;
    wait (frameNo == fr); setCfg(1, 0, 0, 0); fr += 6;
    wait (frameNo == fr); setCfg(2, 0, 0, 0); fr += 10;
    wait (frameNo == fr); setCfg(3, 0, 0, 0); fr += 12;
    wait (frameNo == fr); setCfg(4, 0, 0, 0); fr += 4;
    wait (frameNo == fr); setCfg(0, 0, 0, 0); fr += 18;
    wait (frameNo == fr); setCfg(5, 0, 0, 0); fr += 6;
    wait (frameNo == fr); setCfg(7, 0, 0, 0); fr += 3;
    wait (frameNo == fr); setCfg(2, 0, 0, 0); fr += 10;
    phase = "R5";
    wait (frameNo == fr); setCfg(2, 6, 3, 1); fr += 4;
    wait (frameNo == fr + 2);
    summary();
  end

  initial begin
    #3_800_000;
    fails++;
    $display("FAIL R2 watchdog: reached frame %0d, expected the run to end", frameNo);
    summary();
  end
endmodule